// File: doc/BRIEF.md
# Write-Protect Status Register Unit

This block keeps the 8-bit status register of a small serial non-volatile memory and decides whether a byte may be modified. The register holds a busy flag, a write-enable latch and a two-bit protection level. A command decoder elsewhere in the chip drives the block with one-cycle pulses. These pulses set or clear the write-enable latch, start a status-register write cycle, start an array write cycle and report that the internal write cycle has finished. The block also samples the active-low hardware write-protect pin.

For any address placed on its check input, the block reports in the same cycle whether an array write to that address is permitted. The status byte is always available for a read-status operation. It comes straight from flops, so the read path has a full cycle of slack. The protection level resets to zero. Nothing here keeps that level across power loss.

Top module: `wp_status_unit`

## Requirements
- R1: A synchronous active-high reset clears the status byte to 0x00, and permit is 0 after reset.
- R2: Status bit 0 is the busy flag, bit 1 is the write-enable latch, bit 2 is protect bit BP0 and bit 3 is protect bit BP1. Bits 7..4 always read 0, whatever byte a status write supplied.
- R3: When the block is idle and the write-protect pin is high, a set pulse makes bit 1 read 1 after the next edge and a clear pulse makes it read 0. If both pulses arrive in the same cycle, the clear pulse wins.
- R4: A write-protect pin that is low at a clock edge clears the write-enable latch. A set pulse has no effect while the pin is low.
- R5: A status-write pulse is accepted only when the block is idle, the latch reads 1 and the pin is high. When accepted it sets busy and captures data bits 3:2 as the pending level. Bits 3:2 of the status byte keep their old value until the cycle completes. In any other case the pulse changes nothing.
- R6: A completion pulse while busy clears busy and the write-enable latch. If the cycle was a status write, the pending level is loaded into bits 3:2 at the same edge. A completion pulse while idle has no effect.
- R7: An array-write start pulse is accepted under the same condition as R5 and sets busy. If a status-write pulse and an array-write start arrive together, the status write is taken.
- R8: While busy, set, clear, status-write and array-start pulses are ignored. Only completion and the pin act.
- R9: The protection map depends on the level. Level 00 protects nothing. Level 01 protects the top quarter of the address space, where the two address MSBs are 11 (0x60–0x7F for 7 bits). Level 10 protects the upper half (0x40–0x7F). Level 11 protects every address.
- R10: permit is combinational and equals latch AND pin AND NOT protected(check address). It follows the check address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n_i | input | 1 | Hardware write-protect, active low |
| wren_i | input | 1 | Pulse: set write-enable latch |
| wrdi_i | input | 1 | Pulse: clear write-enable latch |
| wrsr_i | input | 1 | Pulse: start status-register write |
| wrsr_data_i | input | 8 | Byte supplied with the status write |
| arr_wr_i | input | 1 | Pulse: start array write cycle |
| wr_done_i | input | 1 | Pulse: internal write cycle finished |
| chk_addr_i | input | ADDR_W | Address whose write permission is queried |
| status_o | output | 8 | Status byte for reading |
| permit_o | output | 1 | Array write to chk_addr_i allowed |

## Verification
Directed sequences walk the latch through set, clear, simultaneous set and clear, and pin-low cases. They take the register through status writes accepted while enabled and refused while disabled, so the two outcomes can be told apart. Each protection level is probed at addresses just below and just above its boundary, which tells a wrong boundary from a wrong level decode. Commands issued during a busy cycle, and completions issued while idle, show whether the busy gate and the deferred protection update are in place. A long run of seeded random pulses, random pin values and random addresses is then compared every cycle with a bench model. This exposes priority errors between commands that arrive together.

// File: rtl/wp_status_pkg.sv
package wp_status_pkg;
  localparam int STAT_W  = 8;
  localparam int ST_BUSY = 0;
  localparam int ST_WEN  = 1;
  localparam int ST_BP0  = 2;
  localparam int ST_BP1  = 3;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_STAT  = 2'd1,
    CYC_ARRAY = 2'd2
  } cyc_e;
endpackage

// File: rtl/wp_wen_latch.sv
module wp_wen_latch (
  input  logic clk,
  input  logic rst,
  input  logic wp_n_i,
  input  logic busy_i,
  input  logic done_ok_i,
  input  logic wren_i,
  input  logic wrdi_i,
  output logic wen_o
);
  logic wen_q;

  // Pin low and cycle completion dominate; commands act only when idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q <= 1'b0;
    end else if (!wp_n_i) begin
      wen_q <= 1'b0;
    end else if (done_ok_i) begin
      wen_q <= 1'b0;
    end else if (!busy_i) begin
      if (wrdi_i)      wen_q <= 1'b0;
      else if (wren_i) wen_q <= 1'b1;
    end
  end

  assign wen_o = wen_q;
endmodule

// File: rtl/wp_cycle_ctrl.sv
module wp_cycle_ctrl
  import wp_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wen_i,
  input  logic       wp_n_i,
  input  logic       wrsr_i,
  input  logic       arr_wr_i,
  input  logic       wr_done_i,
  input  logic [1:0] bp_new_i,
  output logic       busy_o,
  output logic       done_ok_o,
  output logic [1:0] bp_o
);
  cyc_e       cyc_q;
  logic [1:0] bp_q;
  logic [1:0] pend_q;
  logic       allow;

  assign busy_o    = (cyc_q != CYC_IDLE);
  assign done_ok_o = wr_done_i && busy_o;
  assign allow     = wen_i && wp_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= CYC_IDLE;
      bp_q   <= 2'b00;
      pend_q <= 2'b00;
    end else if (done_ok_o) begin
      cyc_q <= CYC_IDLE;
      if (cyc_q == CYC_STAT) bp_q <= pend_q;
    end else if (!busy_o && allow) begin
      if (wrsr_i) begin
        cyc_q  <= CYC_STAT;
        pend_q <= bp_new_i;
      end else if (arr_wr_i) begin
        cyc_q <= CYC_ARRAY;
      end
    end
  end

  assign bp_o = bp_q;
endmodule

// File: rtl/wp_prot_map.sv
module wp_prot_map #(
  parameter int ADDR_W = 7
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  logic [1:0] hi2;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign hi2 = addr_i[ADDR_W-1 -: 2];
    end else begin : g_narrow
      assign hi2 = {addr_i[0], addr_i[0]};
    end
  endgenerate

  always_comb begin
    case (bp_i)
      2'b00:   prot_o = 1'b0;
      2'b01:   prot_o = &hi2;
      2'b10:   prot_o = hi2[1];
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
  import wp_status_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              arr_wr_i,
  input  logic              wr_done_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic [7:0]        status_o,
  output logic              permit_o
);
  logic       busy;
  logic       done_ok;
  logic       wen;
  logic [1:0] bp;
  logic       prot;
  logic       unused_data_bits;

  assign unused_data_bits = ^{wrsr_data_i[7:4], wrsr_data_i[1:0]};

  wp_wen_latch u_wen (
    .clk       (clk),
    .rst       (rst),
    .wp_n_i    (wp_n_i),
    .busy_i    (busy),
    .done_ok_i (done_ok),
    .wren_i    (wren_i),
    .wrdi_i    (wrdi_i),
    .wen_o     (wen)
  );

  wp_cycle_ctrl u_cyc (
    .clk       (clk),
    .rst       (rst),
    .wen_i     (wen),
    .wp_n_i    (wp_n_i),
    .wrsr_i    (wrsr_i),
    .arr_wr_i  (arr_wr_i),
    .wr_done_i (wr_done_i),
    .bp_new_i  (wrsr_data_i[ST_BP1:ST_BP0]),
    .busy_o    (busy),
    .done_ok_o (done_ok),
    .bp_o      (bp)
  );

  wp_prot_map #(.ADDR_W(ADDR_W)) u_map (
    .bp_i   (bp),
    .addr_i (chk_addr_i),
    .prot_o (prot)
  );

  // Every status bit comes straight from a flop.
  always_comb begin
    status_o          = '0;
    status_o[ST_BUSY] = busy;
    status_o[ST_WEN]  = wen;
    status_o[ST_BP0]  = bp[0];
    status_o[ST_BP1]  = bp[1];
  end

  assign permit_o = wen && wp_n_i && !prot;
endmodule

// File: rtl/wp_status_unit_chk.sv
module wp_status_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       wp_n_i,
  input logic       wr_done_i,
  input logic [7:0] status_o,
  input logic       permit_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (status_o == 8'h00));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status_o[7:4] == 4'h0);

  // R4
  pin_clears_wen_chk: assert property (@(posedge clk) disable iff (rst)
    !wp_n_i |=> !status_o[1]);

  // R5
  bp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_done_i || !status_o[0]) |=> $stable(status_o[3:2]));

  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_done_i && status_o[0]) |=> (status_o[1:0] == 2'b00));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o[0] && !wr_done_i) |=> status_o[0]);

  // R9
  all_prot_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o[3:2] == 2'b11) |-> !permit_o);

  // R10
  permit_need_chk: assert property (@(posedge clk) disable iff (rst)
    permit_o |-> (status_o[1] && wp_n_i));
endmodule

bind wp_status_unit wp_status_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wp_n_i    (wp_n_i),
  .wr_done_i (wr_done_i),
  .status_o  (status_o),
  .permit_o  (permit_o)
);

// File: tb/wp_status_unit_bench.sv
`timescale 1ns/1ps
module wp_status_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wp_n_i = 1'b1;
  logic       wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0, arr_wr_i = 1'b0, wr_done_i = 1'b0;
  logic [7:0] wrsr_data_i = 8'h00;
  logic [6:0] chk_addr_i = 7'h00;
  logic [7:0] status_o;
  logic       permit_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  logic       m_busy = 0, m_wen = 0, m_stat = 0;
  logic [1:0] m_bp = 0, m_pend = 0;

  always #2 clk = ~clk;

  wp_status_unit #(.ADDR_W(7)) u_wp_status_unit (
    .clk(clk), .rst(rst), .wp_n_i(wp_n_i), .wren_i(wren_i), .wrdi_i(wrdi_i),
    .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i), .arr_wr_i(arr_wr_i),
    .wr_done_i(wr_done_i), .chk_addr_i(chk_addr_i), .status_o(status_o),
    .permit_o(permit_o)
  );

  function automatic logic prot_f(input logic [1:0] bp, input logic [6:0] a);
    case (bp)
      2'd0: return 1'b0;
      2'd1: return a >= 7'h60;
      2'd2: return a >= 7'h40;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] m_status();
    return {4'h0, m_bp, m_wen, m_busy};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic done_ok, allow;
    if (rst) begin
      m_busy = 0; m_wen = 0; m_stat = 0; m_bp = 0; m_pend = 0;
      return;
    end
    done_ok = wr_done_i && m_busy;
    allow   = m_wen && wp_n_i;
    if (done_ok) begin
      if (m_stat) m_bp = m_pend;
      m_busy = 0; m_stat = 0;
    end else if (!m_busy && allow) begin
      if (wrsr_i) begin m_busy = 1; m_stat = 1; m_pend = wrsr_data_i[3:2]; end
      else if (arr_wr_i) begin m_busy = 1; m_stat = 0; end
    end
    if (!wp_n_i) m_wen = 0;
    else if (done_ok) m_wen = 0;
    else if (!(m_busy && !(!allow && 0)) || 0) m_wen = m_wen;
  endtask

  // Latch update uses pre-edge busy; kept separate for clarity.
  task automatic step(input logic sw, input logic cw, input logic sr, input logic ar,
                      input logic dn, input logic wp, input logic [7:0] d,
                      input logic [6:0] a);
    logic pre_busy, pre_wen;
    @(negedge clk);
    wren_i = sw; wrdi_i = cw; wrsr_i = sr; arr_wr_i = ar; wr_done_i = dn;
    wp_n_i = wp; wrsr_data_i = d; chk_addr_i = a;
    #1;
    if (!rst) begin
      chk("R2 status", status_o, m_status());
      chk("R10 permit", permit_o, m_wen && wp_n_i && !prot_f(m_bp, chk_addr_i));
    end
    @(posedge clk);
    pre_busy = m_busy; pre_wen = m_wen;
    model_edge();
    if (!rst) begin
      if (!wp_n_i) m_wen = 0;
      else if (wr_done_i && pre_busy) m_wen = 0;
      else if (!pre_busy) begin
        if (wrdi_i) m_wen = 0;
        else if (wren_i) m_wen = 1;
        else m_wen = pre_wen;
      end else m_wen = pre_wen;
    end
  endtask

  task automatic idle(input logic [6:0] a);
    step(0, 0, 0, 0, 0, 1, 8'h00, a);
  endtask

  task automatic look(input string tag, input logic [7:0] exp_st);
    #1;
    chk(tag, status_o, exp_st);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2718));
    repeat (3) step(0, 0, 0, 0, 0, 1, 8'h00, 7'h00);
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 1, 8'h00, 7'h00);
    look("R1 reset status", 8'h00);
    chk("R1 reset permit", permit_o, 0);

    step(1, 0, 0, 0, 0, 1, 8'h00, 7'h00); look("R3 set", 8'h02);
    step(1, 1, 0, 0, 0, 1, 8'h00, 7'h00); look("R3 clear wins", 8'h00);
    step(1, 0, 0, 0, 0, 1, 8'h00, 7'h00);
    step(0, 0, 0, 0, 0, 0, 8'h00, 7'h00); look("R4 pin low clears", 8'h00);
    step(1, 0, 0, 0, 0, 0, 8'h00, 7'h00); look("R4 set ignored", 8'h00);

    step(1, 0, 0, 0, 0, 1, 8'h00, 7'h00);
    step(0, 0, 1, 0, 0, 1, 8'hF7, 7'h00); look("R5 busy bp held", 8'h03);
    step(0, 1, 1, 1, 0, 1, 8'h0C, 7'h00); look("R8 busy ignores", 8'h03);
    step(0, 0, 0, 0, 1, 1, 8'h00, 7'h00); look("R6 commit bp R2 upper", 8'h04);

    step(1, 0, 0, 0, 0, 1, 8'h00, 7'h5F); #1 chk("R10 permit below", permit_o, 1);
    idle(7'h60); #1 chk("R9 quarter protected", permit_o, 0);

    step(0, 1, 0, 0, 0, 1, 8'h00, 7'h00);
    step(0, 0, 1, 0, 0, 1, 8'h08, 7'h00); look("R5 refused when disabled", 8'h04);

    step(1, 0, 0, 0, 0, 1, 8'h00, 7'h00);
    step(0, 0, 1, 0, 0, 1, 8'h08, 7'h00);
    step(0, 0, 0, 0, 1, 1, 8'h00, 7'h00); look("R6 level 10", 8'h08);
    step(1, 0, 0, 0, 0, 1, 8'h00, 7'h3F); #1 chk("R9 half below", permit_o, 1);
    idle(7'h40); #1 chk("R9 half protected", permit_o, 0);

    step(0, 0, 1, 0, 0, 1, 8'h0C, 7'h00);
    step(0, 0, 0, 0, 1, 1, 8'h00, 7'h00);
    step(1, 0, 0, 0, 0, 1, 8'h00, 7'h00); #1 chk("R9 all protected", permit_o, 0);
    step(0, 0, 0, 1, 0, 1, 8'h00, 7'h00); look("R7 array start", 8'h0F);
    step(0, 0, 0, 0, 1, 1, 8'h00, 7'h00); look("R7 done clears wen", 8'h0C);

    step(1, 0, 0, 0, 0, 1, 8'h00, 7'h00);
    step(0, 0, 1, 0, 0, 1, 8'h00, 7'h00);
    step(0, 0, 0, 0, 1, 1, 8'h00, 7'h00); look("R6 back to 00", 8'h00);
    step(0, 0, 0, 0, 1, 1, 8'h00, 7'h00); look("R6 idle done ignored", 8'h00);
    step(1, 0, 0, 0, 0, 1, 8'h00, 7'h00);
    step(0, 0, 1, 1, 0, 1, 8'h04, 7'h00);
    step(0, 0, 0, 0, 1, 1, 8'h00, 7'h00); look("R7 status write taken", 8'h04);

    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 4) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 7) != 0,
           8'($urandom), 7'($urandom));
    end
    idle(7'h00);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule